// File: doc/BRIEF.md
# Serial EEPROM host controller

This block is the master side of a link to a 256-word by 16-bit serial EEPROM. A client hands it one request at a time over a valid/ready handshake: an operation code, an 8-bit word address and, for programming, a 16-bit data word. The controller then drives the chip select, serial clock and serial data lines itself. Each transaction is a frame that opens with a fixed start nibble and a 4-bit opcode, followed by an address field or dummy bits, and for programming a 16-bit data field. Programming requests are automatically preceded by a separate write-enable frame, so the client never has to manage the memory's enable latch.

The serial clock comes from dividing the system clock. Each high or low level of the serial clock lasts `CLK_DIV` system cycles, so the client picks `CLK_DIV` to respect the memory's maximum clock rate. Serial data changes only while the serial clock is low. Read data comes back most significant bit first and is returned with a one-cycle `done` pulse. After a programming frame the controller watches the memory's ready/busy line and reports completion only once it reads ready. If the line stays busy for `TIMEOUT_CYCLES` cycles, the request completes with an error flag.

Top module: `eeh_host`

## Requirements
- R1: Each frame is sent with chip select high. Its first 4 bits are 1010, then comes a 4-bit opcode, then an 8-bit address (dummy zeros for commands without an address), all most significant bit first. Programming frames append 16 data bits, MSB first, for a total of 32 bits. Read frames append 16 clock periods with serial data held at 0. Other command frames are 16 bits long. Opcodes: read 1000, write 0100, write-enable 0011, write-disable 0000, write-all 0001.
- R2: A write or write-all request first sends exactly one 16-bit write-enable frame in its own chip-select window, then the programming frame. This holds even if the client has just issued a write-disable request.
- R3: Serial data and chip select never change while the serial clock is high.
- R4: A read captures the 16 bits the memory presents on its data output after the address field, first bit as bit 15. It returns them on `done_rdata` in the cycle `done` is high.
- R5: Each serial clock level lasts exactly `CLK_DIV` system cycles, and the serial clock is low whenever chip select is low. A read completes `66*CLK_DIV` cycles after the accepting edge.
- R6: Between two frames, chip select stays low for at least `2*CLK_DIV` system cycles.
- R7: After a programming frame, `done` is held back until `mem_rdy` has been sampled high. A write-disable request does not wait on `mem_rdy` and completes `34*CLK_DIV` cycles after the accepting edge.
- R8: `req_ready` is high only while the controller is idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. `req_op` encodes 0 read, 1 write, 2 write-all, 3 write-disable. Each request produces exactly one single-cycle `done` pulse.
- R9: If `mem_rdy` stays low for `TIMEOUT_CYCLES` cycles after a programming frame, the request completes with `done` and `done_err` both high. Otherwise `done_err` is low.
- R10: During reset, chip select, serial clock, serial data and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 write-all, 3 write-disable |
| req_addr | input | 8 | Word address for read and write |
| req_wdata | input | 16 | Data word for write and write-all |
| done | output | 1 | Single-cycle completion pulse |
| done_err | output | 1 | Ready/busy timeout, valid with done |
| done_rdata | output | 16 | Read data, valid with done after a read |
| mem_cs | output | 1 | Chip select to the memory, active high |
| mem_sk | output | 1 | Divided serial clock |
| mem_di | output | 1 | Serial data to the memory |
| mem_do | input | 1 | Serial data from the memory |
| mem_rdy | input | 1 | Memory ready (1) or busy (0) |

## Verification
The bench uses a behavioural memory model that decodes every frame on serial clock rising edges. This model catches a wrong start nibble, a mis-ordered field or a wrong frame length, any of which corrupts a stored word or a read. The bench issues a write-disable immediately before a write, so a controller that skipped the automatic enable would leave the old word in place. It hits the first and last addresses and bit 15 versus bit 0, so a read capture off by one bit would return a shifted word. Programming is tested with a short busy time, a long busy time and a busy line that never clears: a controller that ignored ready/busy would pulse `done` while the model is still busy, and one without the timeout would hang.

// File: rtl/eeh_pkg.sv
package eeh_pkg;

  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int NIB_W     = 4;
  localparam int CMD_W     = 2 * NIB_W + ADDR_W;
  localparam int FRAME_W   = CMD_W + DATA_W;
  localparam int BIT_CNT_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WRALL = 2'd2,
    OP_WRDIS = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_WAIT
  } host_st_e;

  localparam logic [NIB_W-1:0] START_NIB = 4'b1010;
  localparam logic [NIB_W-1:0] OPC_READ  = 4'b1000;
  localparam logic [NIB_W-1:0] OPC_WRITE = 4'b0100;
  localparam logic [NIB_W-1:0] OPC_WREN  = 4'b0011;
  localparam logic [NIB_W-1:0] OPC_WRDIS = 4'b0000;
  localparam logic [NIB_W-1:0] OPC_WRALL = 4'b0001;

  // Opcode nibble sent for the main frame of a request
  function automatic logic [NIB_W-1:0] opcode_of(host_op_e op);
    case (op)
      OP_READ:  return OPC_READ;
      OP_WRITE: return OPC_WRITE;
      OP_WRALL: return OPC_WRALL;
      default:  return OPC_WRDIS;
    endcase
  endfunction

  // Left-justified frame image: start, opcode, address, payload
  function automatic logic [FRAME_W-1:0] make_frame(logic [NIB_W-1:0] opc,
                                                    logic [ADDR_W-1:0] addr,
                                                    logic [DATA_W-1:0] data);
    return {START_NIB, opc, addr, data};
  endfunction

  // Requests that program the array and so need enable and ready/busy wait
  function automatic logic programs(host_op_e op);
    return (op == OP_WRITE) || (op == OP_WRALL);
  endfunction

  // Serial clock periods in a frame
  function automatic logic [BIT_CNT_W-1:0] frame_len(logic has_payload);
    return has_payload ? BIT_CNT_W'(FRAME_W) : BIT_CNT_W'(CMD_W);
  endfunction

endpackage

// File: rtl/eeh_tick.sv
module eeh_tick #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(DIV - 1));
  assign tick = en && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || wrap) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eeh_shifter.sv
module eeh_shifter #(
  parameter int TX_W = 32,
  parameter int RX_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TX_W-1:0] load_val,
  input  logic            shift,
  input  logic            sample,
  input  logic            sdi,
  output logic            msb,
  output logic [RX_W-1:0] rx
);
  logic [TX_W-1:0] tx;

  assign msb = tx[TX_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     tx <= '0;
    else if (load)  tx <= load_val;
    else if (shift) tx <= {tx[TX_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rx <= '0;
    else if (sample) rx <= {rx[RX_W-2:0], sdi};
  end
endmodule

// File: rtl/eeh_timeout.sv
module eeh_timeout #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eeh_host.sv
module eeh_host
  import eeh_pkg::*;
#(
  parameter int CLK_DIV        = 25,
  parameter int TIMEOUT_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] done_rdata,
  output logic              mem_cs,
  output logic              mem_sk,
  output logic              mem_di,
  input  logic              mem_do,
  input  logic              mem_rdy
);

  host_st_e             state;
  host_op_e             op_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    data_q;
  logic                 pend_main;
  logic                 gap_half;
  logic [BIT_CNT_W-1:0] bits_left;

  // Named events shared with the checker
  logic     tick;
  logic     accept;
  logic     rise_evt;
  logic     fall_evt;
  logic     frame_end;
  logic     gap_end;
  logic     sample_evt;
  logic     in_wait;
  logic     tmo_hit;
  host_op_e op_in;

  logic               tx_load;
  logic [FRAME_W-1:0] tx_val;

  assign op_in      = host_op_e'(req_op);
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign rise_evt   = (state == ST_SHIFT) && tick && !mem_sk;
  assign fall_evt   = (state == ST_SHIFT) && tick && mem_sk;
  assign frame_end  = fall_evt && (bits_left == BIT_CNT_W'(1));
  assign gap_end    = (state == ST_GAP) && tick && gap_half;
  assign in_wait    = (state == ST_WAIT);
  assign sample_evt = fall_evt && (op_q == OP_READ) && !pend_main
                      && (bits_left <= BIT_CNT_W'(DATA_W));

  eeh_tick #(.DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state != ST_IDLE),
    .tick  (tick)
  );

  eeh_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_wait),
    .expired (tmo_hit)
  );

  // Frame image selection: enable frame first for programming requests
  always_comb begin
    tx_load = 1'b0;
    tx_val  = '0;
    if (accept) begin
      tx_load = 1'b1;
      if (programs(op_in))       tx_val = make_frame(OPC_WREN, '0, '0);
      else if (op_in == OP_READ) tx_val = make_frame(OPC_READ, req_addr, '0);
      else                       tx_val = make_frame(OPC_WRDIS, '0, '0);
    end else if (gap_end && pend_main) begin
      tx_load = 1'b1;
      tx_val  = make_frame(opcode_of(op_q),
                           (op_q == OP_WRITE) ? addr_q : '0, data_q);
    end
  end

  eeh_shifter #(.TX_W(FRAME_W), .RX_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_val (tx_val),
    .shift    (fall_evt),
    .sample   (sample_evt),
    .sdi      (mem_do),
    .msb      (mem_di),
    .rx       (done_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_q    <= '0;
      pend_main <= 1'b0;
      gap_half  <= 1'b0;
      bits_left <= '0;
      mem_cs    <= 1'b0;
      mem_sk    <= 1'b0;
      done      <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q      <= op_in;
            addr_q    <= req_addr;
            data_q    <= req_wdata;
            pend_main <= programs(op_in);
            bits_left <= frame_len(op_in == OP_READ);
            mem_cs    <= 1'b1;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise_evt) begin
            mem_sk <= 1'b1;
          end else if (fall_evt) begin
            mem_sk    <= 1'b0;
            bits_left <= bits_left - 1'b1;
            if (frame_end) begin
              mem_cs   <= 1'b0;
              gap_half <= 1'b0;
              state    <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            gap_half <= 1'b1;
            if (gap_end) begin
              if (pend_main) begin
                pend_main <= 1'b0;
                bits_left <= frame_len(1'b1);
                mem_cs    <= 1'b1;
                state     <= ST_SHIFT;
              end else if (programs(op_q)) begin
                state <= ST_WAIT;
              end else begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_WAIT: begin
          if (mem_rdy) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (tmo_hit) begin
            done     <= 1'b1;
            done_err <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeh_host_chk.sv
module eeh_host_chk #(
  parameter int CLK_DIV = 25
) (
  input logic clk,
  input logic rst_n,
  input logic mem_cs,
  input logic mem_sk,
  input logic mem_di,
  input logic mem_rdy,
  input logic req_ready,
  input logic done,
  input logic done_err,
  input logic in_wait
);
  localparam int SAT = 65535;

  logic sk_q, cs_q;
  int   sk_run, cs_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_q   <= 1'b0;
      cs_q   <= 1'b0;
      sk_run <= CLK_DIV;
      cs_run <= 2 * CLK_DIV;
    end else begin
      sk_q <= mem_sk;
      cs_q <= mem_cs;
      if (mem_sk != sk_q) sk_run <= 1;
      else if (sk_run < SAT) sk_run <= sk_run + 1;
      if (mem_cs != cs_q) cs_run <= 1;
      else if (cs_run < SAT) cs_run <= cs_run + 1;
    end
  end

  a_r3_di_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sk && $past(mem_sk)) |-> $stable(mem_di));

  a_r3_cs_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sk && $past(mem_sk)) |-> $stable(mem_cs));

  a_r5_sk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> !mem_sk);

  a_r5_level_length: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sk != sk_q) |-> (sk_run >= CLK_DIV));

  a_r6_deselect_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && !cs_q) |-> (cs_run >= 2 * CLK_DIV));

  a_r7_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err && $past(in_wait)) |-> $past(mem_rdy));

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_cs);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

endmodule

bind eeh_host eeh_host_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_cs    (mem_cs),
  .mem_sk    (mem_sk),
  .mem_di    (mem_di),
  .mem_rdy   (mem_rdy),
  .req_ready (req_ready),
  .done      (done),
  .done_err  (done_err),
  .in_wait   (in_wait)
);

// File: tb/tb_eeh_host.sv
`timescale 1ns/1ps
module tb_eeh_host;
  localparam int CDIV = 3;
  localparam int TMO  = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        done, done_err;
  logic [15:0] done_rdata;
  logic        mem_cs, mem_sk, mem_di;
  logic        mem_do = 1'b0;
  logic        mem_rdy = 1'b1;

  always #2 clk = ~clk;

  eeh_host #(.CLK_DIV(CDIV), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .done_err(done_err), .done_rdata(done_rdata),
    .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_di(mem_di),
    .mem_do(mem_do), .mem_rdy(mem_rdy)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [256];
  logic        wen = 1'b0;
  int          ewen_cnt = 0;
  int          bad_frames = 0;
  int          busy_len = 50;
  bit          stuck = 1'b0;
  int          busy_cnt = 0;
  logic [31:0] msh = '0;
  logic [15:0] mcmd;
  int          bitn = 0;
  logic [15:0] rd_word = '0;
  bit          rd_active = 1'b0;
  logic        p_sk = 1'b0, p_cs = 1'b0;

  task automatic start_busy();
    mem_rdy  = 1'b0;
    busy_cnt = busy_len;
  endtask

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt--;
    if (busy_cnt == 0 && !stuck) mem_rdy = 1'b1;
    if (mem_cs && !p_cs) begin
      bitn = 0; msh = '0; rd_active = 1'b0;
    end
    if (mem_cs && mem_sk && !p_sk) begin
      msh = {msh[30:0], mem_di};
      bitn++;
      if (bitn == 16) begin
        if (msh[15:12] != 4'b1010) bad_frames++;
        if (msh[11:8] == 4'b1000) begin
          rd_active = 1'b1;
          rd_word   = mem[msh[7:0]];
        end
      end
      if (rd_active && bitn > 16 && bitn <= 32) mem_do = rd_word[32-bitn];
    end
    if (!mem_cs && p_cs) begin
      mem_do = 1'b0;
      if (bitn == 16) begin
        mcmd = msh[15:0];
        case (mcmd[11:8])
          4'b0011: begin wen = 1'b1; ewen_cnt++; end
          4'b0000: wen = 1'b0;
          default: bad_frames++;
        endcase
      end else if (bitn == 32) begin
        mcmd = msh[31:16];
        case (mcmd[11:8])
          4'b0100: if (wen) begin mem[mcmd[7:0]] = msh[15:0]; start_busy(); end
          4'b0001: if (wen) begin
                     for (int i = 0; i < 256; i++) mem[i] = msh[15:0];
                     start_busy();
                   end
          4'b1000: ;
          default: bad_frames++;
        endcase
      end else begin
        bad_frames++;
      end
    end
    p_sk = mem_sk;
    p_cs = mem_cs;
  end

  // ---------------- line protocol monitor ----------------
  logic q_sk = 1'b0, q_cs = 1'b0, q_di = 1'b0;
  int   hi_run = 0, lo_run = 1000;
  int   r3_bad = 0, r5_bad = 0, r6_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_sk && q_sk && (mem_di != q_di || mem_cs != q_cs)) r3_bad++;
      if (!mem_cs && mem_sk) r5_bad++;
      if (mem_sk) hi_run++;
      else begin
        if (q_sk && hi_run != CDIV) r5_bad++;
        hi_run = 0;
      end
      if (!mem_cs) lo_run++;
      else begin
        if (!q_cs && lo_run < 2 * CDIV) r6_bad++;
        lo_run = 0;
      end
    end
    q_sk = mem_sk; q_cs = mem_cs; q_di = mem_di;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [1:0]  op;
    logic [15:0] rdata;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int   cyc = 0;
  int   t_acc = 0;
  int   last_lat = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "done without a pending request", 1, 0);
      end else begin
        mon_e    = sb.pop_front();
        last_lat = cyc - t_acc;
        check(done_err == mon_e.err, "R9", {mon_e.tag, " error flag"}, done_err, mon_e.err);
        if (mon_e.op == 2'd0 && !mon_e.err)
          check(done_rdata == mon_e.rdata, "R4", {mon_e.tag, " read data"}, done_rdata, mon_e.rdata);
        if ((mon_e.op == 2'd1 || mon_e.op == 2'd2) && !mon_e.err)
          check(mem_rdy == 1'b1, "R7", {mon_e.tag, " done while busy"}, mem_rdy, 1);
      end
    end
  end

  task automatic do_req(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                        input logic [15:0] er, input logic ee, input string tag);
    exp_t x;
    x.op = op; x.rdata = er; x.err = ee; x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    t_acc = cyc;
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8", {tag, " ready while busy"}, req_ready, 0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired before completion", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  int e0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    check(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    check(mem_cs == 1'b0, "R10", "reset cs", mem_cs, 0);
    check(mem_sk == 1'b0, "R10", "reset sk", mem_sk, 0);
    check(mem_di == 1'b0, "R10", "reset di", mem_di, 0);
    check(done == 1'b0, "R10", "reset done", done, 0);
    rst_n = 1'b1;

    e0 = ewen_cnt;
    do_req(2'd1, 8'h12, 16'hA5C3, 16'h0, 1'b0, "write 12");
    check(mem[8'h12] == 16'hA5C3, "R1", "stored word at 12", mem[8'h12], 16'hA5C3);
    check(ewen_cnt == e0 + 1, "R2", "enable frames per write", ewen_cnt, e0 + 1);

    do_req(2'd0, 8'h12, 16'h0, 16'hA5C3, 1'b0, "read 12");
    check(last_lat == 66 * CDIV, "R5", "read latency", last_lat, 66 * CDIV);

    do_req(2'd1, 8'hFF, 16'h0001, 16'h0, 1'b0, "write FF");
    do_req(2'd1, 8'h00, 16'h8000, 16'h0, 1'b0, "write 00");
    do_req(2'd0, 8'hFF, 16'h0, 16'h0001, 1'b0, "read FF");
    do_req(2'd0, 8'h00, 16'h0, 16'h8000, 1'b0, "read 00");

    do_req(2'd3, 8'h00, 16'h0, 16'h0, 1'b0, "write-disable");
    check(wen == 1'b0, "R1", "disable opcode decoded", wen, 0);
    check(last_lat == 34 * CDIV, "R7", "write-disable latency", last_lat, 34 * CDIV);

    @(posedge clk); busy_len = 200;
    e0 = ewen_cnt;
    do_req(2'd1, 8'h40, 16'h1234, 16'h0, 1'b0, "write 40 after disable");
    check(mem[8'h40] == 16'h1234, "R2", "write after disable stored", mem[8'h40], 16'h1234);
    check(ewen_cnt == e0 + 1, "R2", "auto enable after disable", ewen_cnt, e0 + 1);
    do_req(2'd0, 8'h40, 16'h0, 16'h1234, 1'b0, "read 40");

    @(posedge clk); busy_len = 50;
    do_req(2'd2, 8'h00, 16'h5A5A, 16'h0, 1'b0, "write-all");
    check(mem[255] == 16'h5A5A, "R1", "write-all last word", mem[255], 16'h5A5A);
    do_req(2'd0, 8'h00, 16'h0, 16'h5A5A, 1'b0, "read 00 after write-all");
    do_req(2'd0, 8'h77, 16'h0, 16'h5A5A, 1'b0, "read 77 after write-all");

    @(posedge clk); stuck = 1'b1;
    do_req(2'd1, 8'h33, 16'hBEEF, 16'h0, 1'b1, "write 33 stuck busy");
    @(posedge clk); stuck = 1'b0; busy_cnt = 0;
    repeat (4) @(negedge clk);
    check(mem_rdy == 1'b1, "R9", "busy released", mem_rdy, 1);
    do_req(2'd0, 8'h33, 16'h0, 16'hBEEF, 1'b0, "read 33");

    check(bad_frames == 0, "R1", "malformed frames", bad_frames, 0);
    check(r3_bad == 0, "R3", "changes while sk high", r3_bad, 0);
    check(r5_bad == 0, "R5", "sk level faults", r5_bad, 0);
    check(r6_bad == 0, "R6", "short deselect gaps", r6_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule